// File: doc/BRIEF.md
# Lockable Security Control Register Bank

This block is the register file of a configuration controller. It holds a control word whose security and debug fields can be frozen one group at a time by sticky lock bits. It also holds a key register that either grants or revokes access, a small configuration word, and an interrupt status/mask pair that drives one level interrupt line. Software reaches every register through a single-word request port. Each request carries a word index and, for writes, 32 bits of data. The control word is also driven out, so the security logic next to the block can consume it.

The request port never stalls: a request is taken in the cycle `req_valid` is high, so no back-pressure exists. A read returns its data one cycle later on `rsp_data`, qualified by a one-cycle `rsp_valid` pulse. Hardware event lines set interrupt status bits directly. Writing a wrong key closes the port until the next reset.

Word indices: 0 control, 1 lock, 2 configuration, 3 interrupt status, 4 interrupt mask, 5 key. All other indices read as zero and ignore writes.

Top module: `sreg_bank`

## Requirements
- R1: After reset, the registers read as follows: control 0x0C006000 (bits 27, 26, 14 and 13 set), lock 0, configuration 0x50B, interrupt status 0x88020000 (bits 31, 27 and 17 set), and interrupt mask 0xFFFFFFFF. After reset the port is open and `irq` is low.
- R2: The lock register has 5 bits. A write ORs the written value into the current value, so a set bit stays set until reset. Written bits 31:5 have no effect and read as zero.
- R3: On a control write, a field guarded by a set lock bit keeps its old value. The guards are: lock bit 4 guards control bit 12, bit 3 guards 11:9, bit 2 guards 8, bit 1 guards 7, and bit 0 guards 6:0.
- R4: The writable control bits are the mask 0x6F801FFF. Bits 31 (force reset), 28 and 22:13 keep their value on any write.
- R5: Writing 0x757BDF0D to the key register sets control bits 27 and 11:9, whatever the lock state, and leaves the port open.
- R6: Writing the interrupt status register clears each bit written as one. Reserved bits 26:24 and 19 always read as zero.
- R7: `irq` is high exactly when some status bit is set while its mask bit is zero. It follows a status or mask write in the next cycle.
- R8: Only bits 11:4 of the configuration register are writable.
- R9: Writing any other value to the key register clears control bits 27 and 11:9 and closes the port. While the port is closed, reads return zero and writes have no effect, until reset.
- R10: A high `hw_evt` bit sets the matching non-reserved status bit at the next edge, and this set wins over a software clear in the same cycle. A reserved bit on `hw_evt` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word index of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_data | output | 32 | Read data |
| hw_evt | input | 32 | Hardware events that set status bits |
| ctrl_out | output | 32 | Current control word |
| port_open | output | 1 | Low after a wrong key, until reset |
| irq | output | 1 | Level interrupt |

## Verification
Two things can happen in the same cycle: a software write that clears interrupt status bits, and a hardware event that sets one of those same bits. The bench provokes this by driving `hw_evt` during the very cycle in which it writes ones to that status bit. It drives a reserved event bit alongside. A read-back then has to show the hardware set surviving and the reserved bit still zero. A second overlap is a control write landing on fields that a lock written earlier has frozen. The bench judges it by comparing the read-back word with a value computed from the lock map.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int unsigned DW = 32;

  localparam int unsigned IDX_CTRL = 0;
  localparam int unsigned IDX_LOCK = 1;
  localparam int unsigned IDX_CFG  = 2;
  localparam int unsigned IDX_ISR  = 3;
  localparam int unsigned IDX_IMR  = 4;
  localparam int unsigned IDX_KEY  = 5;

  localparam logic [DW-1:0] CTRL_RST   = 32'h0C00_6000;
  localparam logic [DW-1:0] CTRL_WMASK = 32'h6F80_1FFF;
  localparam logic [DW-1:0] CTRL_KEYB  = 32'h0800_0E00;
  localparam logic [DW-1:0] CFG_RST    = 32'h0000_050B;
  localparam logic [DW-1:0] CFG_WMASK  = 32'h0000_0FF0;
  localparam logic [DW-1:0] ISR_RST    = 32'h8802_0000;
  localparam logic [DW-1:0] ISR_RSVD   = 32'h0708_0000;
  localparam logic [DW-1:0] IMR_RST    = 32'hFFFF_FFFF;

  // control fields guarded by each lock bit
  function automatic logic [DW-1:0] guard_mask(input int unsigned idx);
    case (idx)
      0:       guard_mask = 32'h0000_007F;
      1:       guard_mask = 32'h0000_0080;
      2:       guard_mask = 32'h0000_0100;
      3:       guard_mask = 32'h0000_0E00;
      4:       guard_mask = 32'h0000_1000;
      default: guard_mask = '0;
    endcase
  endfunction
endpackage

// File: rtl/sreg_lock_ctrl.sv
module sreg_lock_ctrl
  import sreg_pkg::*;
#(
  parameter int unsigned LOCK_W = 5,
  parameter logic [31:0] KEY    = 32'h757B_DF0D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic              lock_we,
  input  logic              key_we,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     ctrl_q,
  output logic [LOCK_W-1:0] lock_q,
  output logic              key_bad
);
  logic [DW-1:0] part_mask [LOCK_W];
  logic [DW-1:0] frz;
  logic          key_ok;

  for (genvar g = 0; g < LOCK_W; g++) begin : g_guard
    assign part_mask[g] = lock_q[g] ? guard_mask(g) : '0;
  end

  always_comb begin
    frz = '0;
    for (int i = 0; i < LOCK_W; i++) frz = frz | part_mask[i];
  end

  assign key_ok  = key_we && (wdata == KEY);
  assign key_bad = key_we && (wdata != KEY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      lock_q <= '0;
    end else begin
      if (key_ok)
        ctrl_q <= ctrl_q | CTRL_KEYB;
      else if (key_bad)
        ctrl_q <= ctrl_q & ~CTRL_KEYB;
      else if (ctrl_we)
        ctrl_q <= (ctrl_q & ~(CTRL_WMASK & ~frz)) | (wdata & CTRL_WMASK & ~frz);
      if (lock_we)
        lock_q <= lock_q | wdata[LOCK_W-1:0];
    end
  end

  // R2
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lock_q & $past(lock_q)) == $past(lock_q)));
  // R3
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !key_we |=> (((ctrl_q ^ $past(ctrl_q)) & $past(frz)) == '0));
  // R4
  force_rst_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !key_we |=> (ctrl_q[31] == $past(ctrl_q[31])));
endmodule

// File: rtl/sreg_irq.sv
module sreg_irq
  import sreg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          isr_we,
  input  logic          imr_we,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] hw_evt,
  output logic [DW-1:0] isr_q,
  output logic [DW-1:0] imr_q,
  output logic          irq
);
  logic [DW-1:0] clr;
  logic [DW-1:0] setv;

  assign clr  = isr_we ? (wdata & ~ISR_RSVD) : '0;
  assign setv = hw_evt & ~ISR_RSVD;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isr_q <= ISR_RST;
      imr_q <= IMR_RST;
    end else begin
      isr_q <= (isr_q & ~clr) | setv;
      if (imr_we) imr_q <= (wdata & ~ISR_RSVD) | ISR_RSVD;
    end
  end

  assign irq = |(isr_q & ~imr_q);

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(hw_evt & ~ISR_RSVD) & ~isr_q) == '0));
  // R6
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((isr_q & ISR_RSVD) == '0));
endmodule

// File: rtl/sreg_port.sv
module sreg_port
  import sreg_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned LOCK_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic              key_bad,
  input  logic [DW-1:0]     ctrl_q,
  input  logic [LOCK_W-1:0] lock_q,
  input  logic [DW-1:0]     isr_q,
  input  logic [DW-1:0]     imr_q,
  output logic              ctrl_we,
  output logic              lock_we,
  output logic              key_we,
  output logic              isr_we,
  output logic              imr_we,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_data,
  output logic              port_open
);
  logic          wr;
  logic          rd;
  logic          cfg_we;
  logic [DW-1:0] cfg_q;
  logic [DW-1:0] rmux;

  assign wr = req_valid && req_write && port_open;
  assign rd = req_valid && !req_write;

  assign ctrl_we = wr && (req_addr == ADDR_W'(IDX_CTRL));
  assign lock_we = wr && (req_addr == ADDR_W'(IDX_LOCK));
  assign cfg_we  = wr && (req_addr == ADDR_W'(IDX_CFG));
  assign isr_we  = wr && (req_addr == ADDR_W'(IDX_ISR));
  assign imr_we  = wr && (req_addr == ADDR_W'(IDX_IMR));
  assign key_we  = wr && (req_addr == ADDR_W'(IDX_KEY));

  always_comb begin
    rmux = '0;
    if (req_addr == ADDR_W'(IDX_CTRL)) rmux = ctrl_q;
    if (req_addr == ADDR_W'(IDX_LOCK)) rmux = DW'(lock_q);
    if (req_addr == ADDR_W'(IDX_CFG))  rmux = cfg_q;
    if (req_addr == ADDR_W'(IDX_ISR))  rmux = isr_q;
    if (req_addr == ADDR_W'(IDX_IMR))  rmux = imr_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q     <= CFG_RST;
      port_open <= 1'b1;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      if (cfg_we) cfg_q <= (cfg_q & ~CFG_WMASK) | (req_wdata & CFG_WMASK);
      if (key_bad) port_open <= 1'b0;
      rsp_valid <= rd;
      rsp_data  <= (rd && port_open) ? rmux : '0;
    end
  end

  // R9
  closed_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !port_open |=> !port_open);
  // R9
  closed_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !port_open |=> (rsp_data == '0));
  // R8
  cfg_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cfg_q & ~CFG_WMASK) == (CFG_RST & ~CFG_WMASK)));
endmodule

// File: rtl/sreg_bank.sv
module sreg_bank
  import sreg_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned LOCK_W = 5,
  parameter logic [31:0] KEY    = 32'h757B_DF0D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_data,
  input  logic [31:0]       hw_evt,
  output logic [31:0]       ctrl_out,
  output logic              port_open,
  output logic              irq
);
  logic              ctrl_we, lock_we, key_we, isr_we, imr_we, key_bad;
  logic [DW-1:0]     ctrl_q, isr_q, imr_q;
  logic [LOCK_W-1:0] lock_q;

  sreg_port #(.ADDR_W(ADDR_W), .LOCK_W(LOCK_W)) u_port (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .key_bad(key_bad),
    .ctrl_q(ctrl_q), .lock_q(lock_q), .isr_q(isr_q), .imr_q(imr_q),
    .ctrl_we(ctrl_we), .lock_we(lock_we), .key_we(key_we),
    .isr_we(isr_we), .imr_we(imr_we),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .port_open(port_open)
  );

  sreg_lock_ctrl #(.LOCK_W(LOCK_W), .KEY(KEY)) u_lock (
    .clk(clk), .rst_n(rst_n),
    .ctrl_we(ctrl_we), .lock_we(lock_we), .key_we(key_we),
    .wdata(req_wdata), .ctrl_q(ctrl_q), .lock_q(lock_q), .key_bad(key_bad)
  );

  sreg_irq u_irq (
    .clk(clk), .rst_n(rst_n),
    .isr_we(isr_we), .imr_we(imr_we), .wdata(req_wdata), .hw_evt(hw_evt),
    .isr_q(isr_q), .imr_q(imr_q), .irq(irq)
  );

  assign ctrl_out = ctrl_q;

  // R7
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!isr_we && !imr_we && hw_evt == '0 && $stable(isr_q)) |=> $stable(irq));
endmodule

// File: tb/sreg_bank_tb.sv
`timescale 1ns/1ps
module sreg_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic [31:0] hw_evt = '0;
  logic [31:0] ctrl_out;
  logic        port_open;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  sreg_bank u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .hw_evt(hw_evt), .ctrl_out(ctrl_out),
    .port_open(port_open), .irq(irq)
  );

  // {write, addr, req, data, expected}
  localparam int NV = 15;
  localparam logic [72:0] VEC [NV] = '{
    {1'b0, 4'd0, 4'd1, 32'h0, 32'h0C00_6000},   // R1 control
    {1'b0, 4'd2, 4'd1, 32'h0, 32'h0000_050B},   // R1 configuration
    {1'b0, 4'd3, 4'd1, 32'h0, 32'h8802_0000},   // R1 status
    {1'b0, 4'd4, 4'd1, 32'h0, 32'hFFFF_FFFF},   // R1 mask
    {1'b0, 4'd1, 4'd1, 32'h0, 32'h0},           // R1 lock
    {1'b1, 4'd0, 4'd4, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 4'd0, 4'd4, 32'h0, 32'h6F80_7FFF},   // R4 writable mask
    {1'b1, 4'd1, 4'd2, 32'h0000_0005, 32'h0},
    {1'b1, 4'd1, 4'd2, 32'h0000_0002, 32'h0},
    {1'b1, 4'd1, 4'd2, 32'hFFFF_FFE0, 32'h0},
    {1'b0, 4'd1, 4'd2, 32'h0, 32'h0000_0007},   // R2 sticky OR, reserved
    {1'b1, 4'd0, 4'd3, 32'h0, 32'h0},
    {1'b0, 4'd0, 4'd3, 32'h0, 32'h0000_61FF},   // R3 guarded fields hold
    {1'b1, 4'd2, 4'd8, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 4'd2, 4'd8, 32'h0, 32'h0000_0FFB}    // R8 bits 11:4 only
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_valid ? rsp_data : 32'hDEAD_BEEF;
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 port_open", {31'b0, port_open}, 32'h1);
    check("R1 irq", {31'b0, irq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][72]) wr(VEC[i][71:68], VEC[i][63:32]);
      else begin
        rd(VEC[i][71:68], v);
        check($sformatf("R%0d vec%0d", VEC[i][67:64], i), v, VEC[i][31:0]);
      end
    end

    // R5 good key bypasses locks, port stays open
    wr(4'd5, 32'h757B_DF0D);
    check("R5 ctrl", ctrl_out, 32'h0800_6FFF);
    check("R5 open", {31'b0, port_open}, 32'h1);

    // R7 unmask everything
    wr(4'd4, 32'h0);
    check("R7 irq high", {31'b0, irq}, 32'h1);
    // R6 clear one bit
    wr(4'd3, 32'h8000_0000);
    rd(4'd3, v);
    check("R6 w1c", v, 32'h0802_0000);
    wr(4'd3, 32'hFFFF_FFFF);
    rd(4'd3, v);
    check("R6 all clear", v, 32'h0);
    check("R7 irq low", {31'b0, irq}, 32'h0);

    // R10 set and clear collide; reserved event bit 24 ignored
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 4'd3; req_wdata = 32'h0000_2000;
    hw_evt = 32'h0100_2000;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; hw_evt = '0;
    rd(4'd3, v);
    check("R10 set wins", v, 32'h0000_2000);

    // R7 mask gating on one bit
    wr(4'd4, 32'hFFFF_DFFF);
    check("R7 unmasked", {31'b0, irq}, 32'h1);
    wr(4'd4, 32'hFFFF_FFFF);
    check("R7 masked", {31'b0, irq}, 32'h0);

    // R9 wrong key
    wr(4'd5, 32'h0000_0001);
    check("R9 ctrl", ctrl_out, 32'h0000_61FF);
    check("R9 closed", {31'b0, port_open}, 32'h0);
    rd(4'd0, v);
    check("R9 read zero", v, 32'h0);
    wr(4'd4, 32'h0);
    check("R9 write ignored", {31'b0, irq}, 32'h0);
    wr(4'd5, 32'h757B_DF0D);
    check("R9 stays closed", {31'b0, port_open}, 32'h0);
    check("R9 key ignored", ctrl_out, 32'h0000_61FF);

    // R1 reset reopens
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check("R1 reopen", {31'b0, port_open}, 32'h1);
    check("R1 ctrl", ctrl_out, 32'h0C00_6000);
    rd(4'd1, v);
    check("R1 lock cleared", v, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule